// File: doc/BRIEF.md
# Event Timer/Counter Channel

This block is one timer/counter channel of an 8-bit controller. It keeps a 16-bit count as two bytes, a low byte and a high byte. Each counting event is either one core clock or one falling edge on an external count pin, chosen by a source bit. Counting runs only while a run bit is set. When gating is selected, an external gate pin must also be high.

A two-bit mode field picks how the bytes count. In prescale mode the low five bits of the low byte divide the events by 32 before they reach the high byte. In wide mode the two bytes form one 16-bit counter. In reload mode the low byte counts alone and is refilled from the high byte when it wraps. In hold mode the count stays frozen. On every wrap an overflow flag is set and drives the interrupt request. An interrupt acknowledge clears the flag, and so does a software write. Software loads the control byte and both count bytes through a simple write port. Reads return data from a combinational read port.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control register, both count bytes and the overflow flag read as zero, and `irq` is low.
- R2: Register map: address 0 is control, address 1 is the low count byte, address 2 is the high count byte, and address 3 reads zero and ignores writes. The control layout is bits [1:0] mode, bit 2 source (1 = external pin), bit 3 gate enable, bit 4 run, bit 5 overflow flag, and bits [7:6] read zero.
- R3: In mode 0 (prescale) each event advances bits [4:0] of the low byte. When those bits wrap from 31 to 0, the high byte advances. A wrap of the high byte from 0xFF to 0x00 is an overflow. Bits [7:5] of the low byte are untouched.
- R4: In mode 1 (wide) the high and low bytes form one 16-bit counter. A preload of 65536 minus N overflows on exactly the Nth event.
- R5: In mode 2 (reload) the low byte counts alone. When it wraps from 0xFF, it is loaded from the high byte and an overflow occurs. The high byte never changes by counting.
- R6: In mode 3 (hold) the count stays frozen and no overflow occurs, even while running.
- R7: With source 0, an enabled channel counts one event per core clock.
- R8: With source 1, each 1-to-0 transition of `cnt_pin` is one event. The pin passes through a two-flop synchronizer, and the count changes on the third rising clock edge after the fall.
- R9: While the run bit is 0, the count does not change.
- R10: With gate enable set, the channel counts only while the synchronized `gate_pin` is high.
- R11: An overflow sets the flag, and `irq` always equals the flag.
- R12: A one-cycle `irq_ack` clears the flag. If an overflow happens in the same cycle, the set wins.
- R13: A control write with bit 5 = 0 clears the flag. A control write with bit 5 = 1 leaves the flag unchanged.
- R14: A write to either count byte takes the written value. In that cycle the event is dropped completely, with no increment and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| cnt_pin | input | 1 | External count input, asynchronous |
| gate_pin | input | 1 | External gate input, asynchronous |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request, equal to the overflow flag |

## Verification
The bench builds the channel with its default parameters: 8-bit bytes, a 5-bit prescaler and a two-flop synchronizer. With these values every wrap can be reached from a preload within a few events. The prescaler rollover into the high byte takes at most 32 clocks. The synchronizer depth fixes the three-edge latency from a pin fall to a count change, and the bench's pulse timing and sample points are set by that latency.

// File: rtl/tmr_pkg.sv
// Package: shared encodings for the timer/counter channel.
// Assumes an 8-bit register interface with a two-bit address.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_PRESCALE = 2'd0,
        MODE_WIDE     = 2'd1,
        MODE_RELOAD   = 2'd2,
        MODE_HOLD     = 2'd3
    } tmr_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;

    localparam int BIT_SRC  = 2;
    localparam int BIT_GATE = 3;
    localparam int BIT_RUN  = 4;
    localparam int BIT_FLAG = 5;
endpackage

// File: rtl/tmr_pin_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes the pins are slow compared with clk; resets every stage to 0.
module tmr_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] level
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the raw pins in the first flop stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= pin;
                end
            end else begin : g_next
                // Purpose: pass the sample down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign level = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_event_gen.sv
// Module: turns run/gate/source settings and synchronized pins into a
// one-cycle count event. Assumes cnt_lvl and gate_lvl are already synchronous.
module tmr_event_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_lvl,
    input  logic gate_lvl,
    input  logic run,
    input  logic gate_en,
    input  logic src_ext,
    output logic tick
);
    logic cnt_prev_q;
    logic cnt_fall;
    logic enabled;

    // Purpose: remember the previous synchronized count-pin sample.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_prev_q <= 1'b0;
        else        cnt_prev_q <= cnt_lvl;
    end

    // Purpose: qualify the event with run, gate and source select.
    always_comb begin
        cnt_fall = cnt_prev_q & ~cnt_lvl;
        enabled  = run & (~gate_en | gate_lvl);
        tick     = enabled & (src_ext ? cnt_fall : 1'b1);
    end
endmodule

// File: rtl/tmr_count_core.sv
// Module: the two count bytes and the mode-dependent advance logic.
// Assumes PRE_W <= BYTE_W. Software writes to a byte win over an event.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              ovf
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
    logic [PRE_W-1:0]  pre;
    logic [CNT_W-1:0]  wide_n;

    // Purpose: compute next count bytes and the overflow pulse.
    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        ovf    = 1'b0;
        pre    = lo_q[PRE_W-1:0];
        wide_n = {hi_q, lo_q} + 1'b1;
        if (tick && !wr_lo && !wr_hi) begin
            unique case (mode)
                MODE_PRESCALE: begin
                    if (&pre) begin
                        lo_n[PRE_W-1:0] = '0;
                        hi_n            = hi_q + 1'b1;
                        ovf             = &hi_q;
                    end else begin
                        lo_n[PRE_W-1:0] = pre + 1'b1;
                    end
                end
                MODE_WIDE: begin
                    lo_n = wide_n[BYTE_W-1:0];
                    hi_n = wide_n[CNT_W-1:BYTE_W];
                    ovf  = &{hi_q, lo_q};
                end
                MODE_RELOAD: begin
                    if (&lo_q) begin
                        lo_n = hi_q;
                        ovf  = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
                default: begin
                    lo_n = lo_q;
                end
            endcase
        end
        if (wr_lo) lo_n = wr_data;
        if (wr_hi) hi_n = wr_data;
    end

    // Purpose: hold the count bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign lo = lo_q;
    assign hi = hi_q;
endmodule

// File: rtl/tmr_channel.sv
// Module: top of one timer/counter channel: control register, overflow flag,
// read mux, pin synchronizer, event generator and count core.
// Assumes one register write per cycle; reads are combinational.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PRE_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              cnt_pin,
    input  logic              gate_pin,
    input  logic              irq_ack,
    output logic              irq
);
    localparam int PIN_N = 2;
    localparam int CTRL_USED = BIT_FLAG + 1;

    tmr_mode_e         mode_q;
    logic              src_q, gate_q, run_q, flag_q;
    logic              wr_ctrl, wr_lo, wr_hi;
    logic [PIN_N-1:0]  pin_lvl;
    logic              tick, ovf;
    logic [BYTE_W-1:0] cnt_lo, cnt_hi;
    logic [CTRL_USED-1:0] ctrl_rd;

    // Purpose: decode the write strobe per register.
    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        wr_lo   = wr_en && (wr_addr == ADDR_LO);
        wr_hi   = wr_en && (wr_addr == ADDR_HI);
    end

    // Purpose: hold the control fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PRESCALE;
            src_q  <= 1'b0;
            gate_q <= 1'b0;
            run_q  <= 1'b0;
        end else if (wr_ctrl) begin
            mode_q <= tmr_mode_e'(wr_data[1:0]);
            src_q  <= wr_data[BIT_SRC];
            gate_q <= wr_data[BIT_GATE];
            run_q  <= wr_data[BIT_RUN];
        end
    end

    // Purpose: overflow flag; a set beats either clear source.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     flag_q <= 1'b0;
        else if (ovf)                                   flag_q <= 1'b1;
        else if (irq_ack)                               flag_q <= 1'b0;
        else if (wr_ctrl && !wr_data[BIT_FLAG])         flag_q <= 1'b0;
    end

    tmr_pin_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({gate_pin, cnt_pin}),
        .level (pin_lvl)
    );

    tmr_event_gen u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_lvl  (pin_lvl[0]),
        .gate_lvl (pin_lvl[1]),
        .run      (run_q),
        .gate_en  (gate_q),
        .src_ext  (src_q),
        .tick     (tick)
    );

    tmr_count_core #(
        .BYTE_W (BYTE_W),
        .PRE_W  (PRE_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .tick    (tick),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .lo      (cnt_lo),
        .hi      (cnt_hi),
        .ovf     (ovf)
    );

    // Purpose: combinational read mux.
    always_comb begin
        ctrl_rd = {flag_q, run_q, gate_q, src_q, mode_q};
        unique case (rd_addr)
            ADDR_CTRL: rd_data = BYTE_W'(ctrl_rd);
            ADDR_LO:   rd_data = cnt_lo;
            ADDR_HI:   rd_data = cnt_hi;
            default:   rd_data = '0;
        endcase
    end

    assign irq = flag_q;
endmodule

// File: rtl/tmr_channel_chk.sv
// Checker: temporal properties of the timer/counter channel, bound to the top.
module tmr_channel_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic              irq_ack,
    input logic              irq,
    input logic [1:0]        mode,
    input logic              run,
    input logic              ovf,
    input logic [BYTE_W-1:0] lo,
    input logic [BYTE_W-1:0] hi
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (wr_addr == 2'd1 || wr_addr == 2'd2);

    a_r9_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable({hi, lo}));

    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && !cnt_wr) |=> ($stable({hi, lo}) && !$rose(irq)));

    a_r5_reload_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !(wr_en && wr_addr == 2'd2)) |=> $stable(hi));

    a_r11_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> irq);

    a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !ovf) |=> !irq);

    a_r14_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> (lo == $past(wr_data)));
endmodule

bind tmr_channel tmr_channel_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq_ack (irq_ack),
    .irq     (irq),
    .mode    (mode_q),
    .run     (run_q),
    .ovf     (ovf),
    .lo      (cnt_lo),
    .hi      (cnt_hi)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cnt_pin = 1'b1;
    logic       gate_pin = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;

    tmr_channel u_tmr_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_pin(cnt_pin), .gate_pin(gate_pin), .irq_ack(irq_ack), .irq(irq)
    );

    function automatic logic [7:0] ctl(input int md, input bit src, input bit gt,
                                       input bit run, input bit keep);
        return {2'b00, keep, run, gt, src, md[1:0]};
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Driver tasks: called at a falling edge, return at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_val(input int sel, input logic [7:0] e, input string tag);
        item_t it;
        if (sel < 4) rd_addr = sel[1:0];
        it.sel = sel; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic fall_pulse();
        cnt_pin = 1'b0;
        repeat (3) @(negedge clk);
        cnt_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // Monitor: pops expected items mid-phase and compares.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                act = (it.sel == 4) ? {7'b0, irq} : rd_data;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        expect_val(0, 8'h00, "R1 ctrl");
        expect_val(1, 8'h00, "R1 lo");
        expect_val(2, 8'h00, "R1 hi");
        expect_val(4, 8'h00, "R1 irq");

        // R2: register map readback
        wr(0, ctl(2, 1, 1, 0, 1));
        expect_val(0, 8'h0E, "R2 ctrl fields");
        wr(3, 8'hAA);
        expect_val(3, 8'h00, "R2 addr3 reads zero");
        expect_val(1, 8'h00, "R2 addr3 write ignored lo");

        // R9: stopped channel does not count
        wr(0, ctl(1, 0, 0, 0, 1));
        wr(1, 8'h10);
        repeat (5) @(negedge clk);
        expect_val(1, 8'h10, "R9 no count while stopped");

        // R7 + R4: timer source, wide mode, 3 ticks from FFFE -> 0001 with overflow
        wr(1, 8'hFE); wr(2, 8'hFF);
        wr(0, ctl(1, 0, 0, 1, 1));
        repeat (2) @(negedge clk);
        wr(0, ctl(1, 0, 0, 0, 1));
        expect_val(1, 8'h01, "R4 wide lo");
        expect_val(2, 8'h00, "R4 wide hi");
        expect_val(4, 8'h01, "R11 irq after wide overflow");

        // R12: acknowledge clears
        ack();
        expect_val(4, 8'h00, "R12 ack clears");

        // R7: wide count without overflow, 5 ticks
        wr(1, 8'h20); wr(2, 8'h07);
        wr(0, ctl(1, 0, 0, 1, 1));
        repeat (4) @(negedge clk);
        wr(0, ctl(1, 0, 0, 0, 1));
        expect_val(1, 8'h25, "R7 one event per clock");
        expect_val(4, 8'h00, "R7 no overflow");

        // R3: prescale mode, lo5=30 hi=12, 4 ticks -> lo=02 hi=13
        wr(1, 8'hFE); wr(2, 8'h12);
        wr(0, ctl(0, 0, 0, 1, 1));
        repeat (3) @(negedge clk);
        wr(0, ctl(0, 0, 0, 0, 1));
        expect_val(1, 8'hE2, "R3 prescale lo, upper bits kept");
        expect_val(2, 8'h13, "R3 prescale hi advanced");
        // R3: high byte wrap overflows
        wr(1, 8'h1F); wr(2, 8'hFF);
        wr(0, ctl(0, 0, 0, 1, 1));
        wr(0, ctl(0, 0, 0, 0, 1));
        expect_val(2, 8'h00, "R3 hi wrapped");
        expect_val(4, 8'h01, "R3 overflow flag");
        // R13: control write with bit5=1 keeps, bit5=0 clears
        wr(0, ctl(0, 0, 0, 0, 1));
        expect_val(4, 8'h01, "R13 keep flag");
        wr(0, ctl(0, 0, 0, 0, 0));
        expect_val(0, 8'h00, "R13 software clear");

        // R5: reload mode, hi=A0 lo=FE, 4 ticks -> lo=A2
        wr(1, 8'hFE); wr(2, 8'hA0);
        wr(0, ctl(2, 0, 0, 1, 1));
        repeat (3) @(negedge clk);
        wr(0, ctl(2, 0, 0, 0, 1));
        expect_val(1, 8'hA2, "R5 reload lo");
        expect_val(2, 8'hA0, "R5 hi unchanged");
        expect_val(4, 8'h01, "R5 reload overflow");
        ack();

        // R6: hold mode frozen
        wr(1, 8'hFF); wr(2, 8'hFF);
        wr(0, ctl(3, 0, 0, 1, 1));
        repeat (5) @(negedge clk);
        wr(0, ctl(3, 0, 0, 0, 1));
        expect_val(1, 8'hFF, "R6 hold lo");
        expect_val(4, 8'h00, "R6 hold no flag");

        // R10: gate low blocks, gate high counts
        wr(1, 8'h00); wr(2, 8'h00);
        wr(0, ctl(1, 0, 1, 1, 1));
        repeat (5) @(negedge clk);
        wr(0, ctl(1, 0, 1, 0, 1));
        expect_val(1, 8'h00, "R10 gate low blocks");
        gate_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(0, ctl(1, 0, 1, 1, 1));
        repeat (2) @(negedge clk);
        wr(0, ctl(1, 0, 1, 0, 1));
        expect_val(1, 8'h03, "R10 gate high counts");

        // R14: write beats event
        wr(1, 8'h00); wr(2, 8'h30);
        wr(0, ctl(1, 0, 0, 1, 1));
        wr(1, 8'h40);
        wr(0, ctl(1, 0, 0, 0, 1));
        expect_val(1, 8'h41, "R14 write wins then one tick");
        expect_val(2, 8'h30, "R14 hi untouched");
        // R14: write during overflow event suppresses the overflow
        wr(1, 8'hFF); wr(2, 8'hFF);
        wr(0, ctl(1, 0, 0, 1, 1));
        wr(1, 8'h05);
        wr(0, ctl(1, 0, 0, 0, 1));
        expect_val(1, 8'h06, "R14 lo");
        expect_val(4, 8'h00, "R14 overflow dropped");

        // R8: external count, preload FFFB, 5 falls overflow
        wr(1, 8'hFB); wr(2, 8'hFF);
        wr(0, ctl(1, 1, 0, 1, 1));
        repeat (4) @(negedge clk);
        expect_val(1, 8'hFB, "R8 idle pin no count");
        for (int i = 0; i < 4; i++) fall_pulse();
        expect_val(1, 8'hFF, "R8 four falls");
        expect_val(4, 8'h00, "R8 no overflow yet");
        fall_pulse();
        expect_val(1, 8'h00, "R8 fifth fall wraps");
        expect_val(4, 8'h01, "R11 irq on pin overflow");
        // R8: latency is three edges after the fall
        wr(0, ctl(1, 1, 0, 1, 0));
        cnt_pin = 1'b0;
        repeat (2) @(negedge clk);
        expect_val(1, 8'h00, "R8 not yet after two edges");
        expect_val(1, 8'h01, "R8 counted at third edge");
        cnt_pin = 1'b1;
        repeat (3) @(negedge clk);

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        summary();
    end
endmodule